// File: doc/BRIEF.md
# Boot-Flash Access Guard Register

This block is one 8-bit configuration register in a bridge's configuration space. It controls host access to a boot-flash region. Host software writes and reads the register through a simple single-cycle port. A write that hits the register's offset updates its writable fields. A read at that offset returns the current contents at once, without a clock. Accesses to any other offset do not touch the register and read back as zero.

The register holds four things: a write-enable bit, a lock bit, and a two-bit read-policy field for the flash region. It also mirrors an external top-swap status input, which software can read but not write. The write-enable bit decides whether host write cycles aimed at the flash region pass through. A write cycle that arrives while writes are disabled is dropped and reported by a one-cycle pulse.

Once the lock bit is set, it stays set until platform reset. While the lock is set, any attempt to turn the write-enable bit from 0 to 1 raises a one-cycle system-management interrupt request. This lets the interrupt handler decide whether the update is allowed.

Top module: `bootrom_guard`

## Requirements
- R1: After platform reset (`rst_n` low), bits 3:0 are 0, and `smi_req`, `blocked_write`, `bios_write_allow` and `invalid_cfg` are all low.
- R2: Bits 7:5 always read as 0. Values written to them are discarded.
- R3: Bit 4 reads back the current level of `top_swap_in`. Writes to bit 4 have no effect.
- R4: Bits 3:2 are a read-write policy field that takes write data bits 3:2. Bit 3 drives `prefetch_en` and bit 2 drives `cache_dis`.
- R5: `invalid_cfg` is high exactly while the policy field holds 11b. The value 11b is still stored and reads back.
- R6: Bit 1 (lock) becomes 1 when a write carries a 1 in bit 1. A write carrying 0 leaves it unchanged. Only `rst_n` clears it.
- R7: Bit 0 (write enable) takes write data bit 0 on every write at the offset. `bios_write_allow` equals bit 0 at all times.
- R8: `smi_req` is high for exactly one cycle, the cycle after a write at the offset, when three things hold: the write data has bit 0 = 1, the stored bit 0 was 0, and the stored lock was already 1 before that write. In every other cycle it is low, including after a single write that sets the lock and the write enable together.
- R9: `region_wr_fwd` equals `region_wr_req` when `bios_write_allow` is high, and is 0 otherwise. A `region_wr_req` seen while `bios_write_allow` is low produces a one-cycle `blocked_write` pulse in the following cycle.
- R10: Reads and writes at any offset other than `REG_OFFSET` (default DCh) leave the register unchanged. `cfg_rdata` is 0 whenever the current cycle is not a read at the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, active low, asynchronous |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration offset |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data (combinational) |
| top_swap_in | input | 1 | External top-swap status |
| region_wr_req | input | 1 | Host write cycle aimed at the flash region |
| region_wr_fwd | output | 1 | Write cycle forwarded to the flash region |
| blocked_write | output | 1 | Pulse: a region write was dropped |
| bios_write_allow | output | 1 | Region writes currently permitted |
| prefetch_en | output | 1 | Read-policy prefetch enable |
| cache_dis | output | 1 | Read-policy cache disable |
| invalid_cfg | output | 1 | Policy field holds the reserved value 11b |
| smi_req | output | 1 | One-cycle system-management interrupt request |

## Verification
The hardest case is the interrupt condition. It needs three things at once: the lock already armed, the stored write enable at 0, and write data with bit 0 set. Reaching it also requires that the same write that arms the lock does not itself count. The bench therefore resets the block and loads each of the sixteen combinations of stored policy, lock and write enable. For each one it applies all 256 write-data values. It then compares the interrupt pulse, the readback and the status outputs against values worked out arithmetically from the prior state and the data.

// File: rtl/bg_pkg.sv
package bg_pkg;
   // Bit positions of the control fields; the read mux and decode depend on them.
   localparam int unsigned WEN_BIT   = 0;
   localparam int unsigned LOCK_BIT  = 1;
   localparam int unsigned CDIS_BIT  = 2;
   localparam int unsigned PREF_BIT  = 3;
   localparam int unsigned TSWAP_BIT = 4;
   localparam int unsigned USED_W    = 5;

   typedef struct packed {
      logic [1:0] policy;   // [1] prefetch enable, [0] cache disable
      logic       lock;
      logic       wen;
   } bg_state_t;

   localparam bg_state_t BG_RESET = '{policy: 2'b00, lock: 1'b0, wen: 1'b0};
endpackage

// File: rtl/bg_ctl_reg.sv
module bg_ctl_reg
   import bg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output bg_state_t         state_q
);
   bg_state_t state_d;

   always_comb begin
      state_d = state_q;
      if (wr_hit) begin
         state_d.policy = wdata[PREF_BIT:CDIS_BIT];
         state_d.lock   = state_q.lock | wdata[LOCK_BIT];
         state_d.wen    = wdata[WEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= BG_RESET;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/bg_smi_gen.sv
module bg_smi_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wdata_wen,
   input  logic wen_q,
   input  logic lock_q,
   output logic smi_req
);
   logic fire;

   assign fire = wr_hit & wdata_wen & ~wen_q & lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smi_req <= 1'b0;
      else        smi_req <= fire;
   end
endmodule

// File: rtl/bg_region_gate.sv
module bg_region_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req,
   input  logic allow,
   output logic wr_fwd,
   output logic blocked
);
   assign wr_fwd = wr_req & allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blocked <= 1'b0;
      else        blocked <= wr_req & ~allow;
   end
endmodule

// File: rtl/bootrom_guard.sv
module bootrom_guard
   import bg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REG_OFFSET = 'hDC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic              cfg_rd_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              top_swap_in,
   input  logic              region_wr_req,
   output logic              region_wr_fwd,
   output logic              blocked_write,
   output logic              bios_write_allow,
   output logic              prefetch_en,
   output logic              cache_dis,
   output logic              invalid_cfg,
   output logic              smi_req
);
   localparam int unsigned RSVD_W = DATA_W - USED_W;
   localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

   if (DATA_W < USED_W) begin : g_bad_data_w
      $error("bootrom_guard: DATA_W must be at least 5");
   end
   if (ADDR_W < 1 || REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
      $error("bootrom_guard: REG_OFFSET does not fit in ADDR_W");
   end

   bg_state_t   st_q;
   logic        addr_hit, wr_hit, rd_hit;
   logic        lock_bit, wen_bit;
   logic [USED_W-1:0] used_bits;

   assign addr_hit = (cfg_addr == OFFS);
   assign wr_hit   = cfg_wr_en & addr_hit;
   assign rd_hit   = cfg_rd_en & addr_hit;

   bg_ctl_reg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .wdata   (cfg_wdata),
      .state_q (st_q)
   );

   assign lock_bit = st_q.lock;
   assign wen_bit  = st_q.wen;

   bg_smi_gen u_smi (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit),
      .wdata_wen (cfg_wdata[WEN_BIT]),
      .wen_q     (wen_bit),
      .lock_q    (lock_bit),
      .smi_req   (smi_req)
   );

   bg_region_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (region_wr_req),
      .allow   (wen_bit),
      .wr_fwd  (region_wr_fwd),
      .blocked (blocked_write)
   );

   assign bios_write_allow = wen_bit;
   assign prefetch_en      = st_q.policy[1];
   assign cache_dis        = st_q.policy[0];
   assign invalid_cfg      = &st_q.policy;

   assign used_bits = {top_swap_in, st_q.policy, st_q.lock, st_q.wen};

   if (RSVD_W > 0) begin : g_rsvd
      assign cfg_rdata = rd_hit ? {{RSVD_W{1'b0}}, used_bits} : '0;
   end else begin : g_norsvd
      assign cfg_rdata = rd_hit ? used_bits : '0;
   end
endmodule

// File: rtl/bg_guard_chk.sv
module bg_guard_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REG_OFFSET = 'hDC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic              cfg_rd_en,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              top_swap_in,
   input logic              region_wr_req,
   input logic              region_wr_fwd,
   input logic              blocked_write,
   input logic              bios_write_allow,
   input logic              invalid_cfg,
   input logic              smi_req,
   input logic              lock_bit,
   input logic              wen_bit
);
   logic hit_w, hit_r, qual;
   assign hit_w = cfg_wr_en && (cfg_addr == ADDR_W'(REG_OFFSET));
   assign hit_r = cfg_rd_en && (cfg_addr == ADDR_W'(REG_OFFSET));
   assign qual  = hit_w && cfg_wdata[0] && !wen_bit && lock_bit;

   // R6
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_bit |=> lock_bit);
   // R8
   smi_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual |=> smi_req);
   // R8
   smi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |=> !smi_req);
   // R9
   fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      region_wr_fwd |-> (region_wr_req && bios_write_allow));
   // R9
   blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (region_wr_req && !bios_write_allow) |=> blocked_write);
   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_r |-> ((cfg_rdata >> 5) == '0));
   // R3
   tswap_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_r |-> (cfg_rdata[4] == top_swap_in));
   // R5
   invalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(invalid_cfg) |-> $past(hit_w && cfg_wdata[3:2] == 2'b11));
   // R7
   allow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_w |=> $stable(bios_write_allow));
   // R10
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_r |-> (cfg_rdata == '0));
endmodule

bind bootrom_guard bg_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
   .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
   .top_swap_in(top_swap_in), .region_wr_req(region_wr_req),
   .region_wr_fwd(region_wr_fwd), .blocked_write(blocked_write),
   .bios_write_allow(bios_write_allow), .invalid_cfg(invalid_cfg),
   .smi_req(smi_req), .lock_bit(lock_bit), .wen_bit(wen_bit)
);

// File: tb/bootrom_guard_bench.sv
`timescale 1ns/1ps
module bootrom_guard_bench;
   localparam int OFF = 'hDC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
   logic [7:0] cfg_addr = '0, cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       top_swap_in = 1'b0, region_wr_req = 1'b0;
   logic       region_wr_fwd, blocked_write, bios_write_allow;
   logic       prefetch_en, cache_dis, invalid_cfg, smi_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bootrom_guard u_bootrom_guard (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .top_swap_in(top_swap_in), .region_wr_req(region_wr_req),
      .region_wr_fwd(region_wr_fwd), .blocked_write(blocked_write),
      .bios_write_allow(bios_write_allow), .prefetch_en(prefetch_en),
      .cache_dis(cache_dis), .invalid_cfg(invalid_cfg), .smi_req(smi_req)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   // write at negedge, captured at next posedge; returns at the following negedge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      cfg_rd_en = 1'b1; cfg_addr = a;
      #1 d = cfg_rdata;
      cfg_rd_en = 1'b0; cfg_addr = '0;
   endtask

   initial begin
      logic [7:0] r, exp_r;
      do_reset();
      // R1 reset state
      rd(OFF, r);
      chk("R1 rdata", r, 8'h00);
      chk("R1 outputs", {4'b0, smi_req, blocked_write, bios_write_allow, invalid_cfg}, 8'h00);

      // Sweep: every prior state (4 bits) x every write value
      for (int init = 0; init < 16; init++) begin
         for (int wd = 0; wd < 256; wd++) begin
            logic [7:0] d;
            logic ilock, iwen, smi_exp, nlock;
            d = 8'(wd);
            ilock = init[1]; iwen = init[0];
            top_swap_in = d[5] ^ d[6];
            do_reset();
            wr(8'(OFF), 8'(init));
            if (wd == 0) begin
               // R8: a write setting lock and enable together does not interrupt
               chk("R8 no smi on initial load", {7'b0, smi_req}, 8'h00);
            end
            wr(8'(OFF), d);
            smi_exp = d[0] & ~iwen & ilock;
            nlock   = ilock | d[1];
            chk("R8 smi pulse", {7'b0, smi_req}, {7'b0, smi_exp});
            rd(OFF, r);
            exp_r = {3'b000, top_swap_in, d[3:2], nlock, d[0]};
            chk("R2 R3 R4 R6 R7 readback", r, exp_r);
            chk("R4 R5 R7 outputs", {4'b0, prefetch_en, cache_dis, invalid_cfg, bios_write_allow},
                {4'b0, d[3], d[2], d[3] & d[2], d[0]});
            @(negedge clk);
            chk("R8 single cycle", {7'b0, smi_req}, 8'h00);
         end
      end

      // R6: lock survives a clearing write, clears only on reset
      do_reset();
      wr(8'(OFF), 8'h02);
      wr(8'(OFF), 8'h00);
      rd(OFF, r);
      chk("R6 lock sticky", r & 8'h02, 8'h02);
      do_reset();
      rd(OFF, r);
      chk("R6 lock cleared by reset", r, 8'h00);

      // R3: mirror follows input live
      top_swap_in = 1'b1; rd(OFF, r); chk("R3 tswap high", r, 8'h10);
      top_swap_in = 1'b0; rd(OFF, r); chk("R3 tswap low", r, 8'h00);

      // R10: other offsets
      wr(8'(OFF + 1), 8'h0F);
      wr(8'(OFF - 1), 8'h0F);
      rd(OFF, r); chk("R10 miss write no effect", r, 8'h00);
      wr(8'(OFF), 8'h0D);
      rd(8'(OFF + 1), r); chk("R10 miss read zero", r, 8'h00);
      chk("R10 idle rdata zero", cfg_rdata, 8'h00);

      // R9: gating with enable set, then cleared
      region_wr_req = 1'b1; #1;
      chk("R9 forwarded", {7'b0, region_wr_fwd}, 8'h01);
      @(negedge clk);
      chk("R9 no block when allowed", {7'b0, blocked_write}, 8'h00);
      region_wr_req = 1'b0;
      wr(8'(OFF), 8'h00);
      region_wr_req = 1'b1; #1;
      chk("R9 dropped", {7'b0, region_wr_fwd}, 8'h00);
      @(negedge clk);
      region_wr_req = 1'b0;
      chk("R9 blocked pulse", {7'b0, blocked_write}, 8'h01);
      @(negedge clk);
      chk("R9 blocked one cycle", {7'b0, blocked_write}, 8'h00);

      // R8: locked, second 0->1 attempt after disable also fires
      do_reset();
      wr(8'(OFF), 8'h03);
      chk("R8 combined set quiet", {7'b0, smi_req}, 8'h00);
      wr(8'(OFF), 8'h02);
      wr(8'(OFF), 8'h03);
      chk("R8 relock attempt fires", {7'b0, smi_req}, 8'h01);
      wr(8'(OFF), 8'h03);
      chk("R8 already enabled quiet", {7'b0, smi_req}, 8'h00);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule